// File: doc/BRIEF.md
# Programmable Interval Timer with Reload

This block is a byte-wide, memory-mapped timer for a small processor bus. It holds a 16-bit free-running base counter that advances on every base tick, a clock-enable pulse that arrives once per system T-cycle. The upper byte of this counter is exposed as a readable divider value. An 8-bit count register advances at one of four selectable fractions of the tick rate, and only while a control bit allows it.

When the count register would carry past 0xFF, it is loaded from a programmable reload register instead of wrapping. A single-cycle interrupt request is raised at the same time. Software programs the reload value, the rate and the enable through the four registers, and restarts the rate phase by writing anything to the divider.

Top module: `interval_timer`

## Requirements
- R1: After synchronous reset the divider, count and reload registers read 0x00, the control register reads 0xF8 and `irq` is low.
- R2: Registers decode at BASE_ADDR (default 0xFF04) plus an offset: divider at +0, count at +1, reload at +2, control at +3. Any other address reads 0x00, and a write there changes no register.
- R3: The divider reads bits 15:8 of an internal 16-bit counter. That counter adds one on every clock where `tick` is high, whether or not the count register is enabled.
- R4: A write of any data to the divider offset clears the internal 16-bit counter to zero on that edge, which restarts the rate phase. That cycle's tick then produces no count increment.
- R5: Control bit 2 enables counting. While it is 0, the count register changes only through bus writes.
- R6: Control bits 1:0 pick the count period in ticks: 00 gives 1024, 01 gives 16, 10 gives 64 and 11 gives 256. The count register adds one on each tick that brings the internal counter's low bits (below the period) to zero.
- R7: An increment from 0xFF loads the count register with the reload value held before that edge.
- R8: Each such reload drives `irq` high for exactly the one cycle that follows the edge.
- R9: A bus write to the count register takes priority over an increment or reload in the same cycle. The written value lands, and no interrupt is raised.
- R10: Control bits 7:3 read back as 1. Writes to the count, reload and control registers are visible on `rd_data` from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Base clock enable, one per T-cycle |
| addr | input | ADDR_W | Bus address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data for `addr` |
| irq | output | 1 | One-cycle interrupt request on reload |

## Verification
A bus write to the count register can land on the same edge as an overflow reload. The bench provokes this by loading 0xFF, clearing the divider to zero the phase, and issuing the write on exactly the sixteenth tick at the fastest rate. It judges the result by the count reading the written value with `irq` staying low. A divider clear can likewise coincide with an increment tick; random traffic hits that case, and each cycle is compared against a bench model built from the requirements.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int REG_W  = 8;
    localparam int BASE_W = 16;
    localparam int N_REGS = 4;

    typedef enum logic [1:0] {
        OFS_DIV  = 2'd0,
        OFS_CNT  = 2'd1,
        OFS_RLD  = 2'd2,
        OFS_CTRL = 2'd3
    } reg_ofs_e;

    typedef struct packed {
        logic div;
        logic cnt;
        logic rld;
        logic ctrl;
    } wr_sel_t;

    typedef struct packed {
        logic       run;
        logic [1:0] rate;
    } ctrl_t;

    // low-bit mask of the base counter for each rate code
    function automatic logic [BASE_W-1:0] rate_mask(input logic [1:0] code);
        case (code)
            2'b00:   rate_mask = 16'd1023;
            2'b01:   rate_mask = 16'd15;
            2'b10:   rate_mask = 16'd63;
            default: rate_mask = 16'd255;
        endcase
    endfunction

endpackage

// File: rtl/tmr_decode.sv
module tmr_decode
    import tmr_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter [ADDR_W-1:0] BASE_ADDR = 16'hFF04
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  div_val,
    input  logic [REG_W-1:0]  cnt_val,
    input  logic [REG_W-1:0]  rld_val,
    input  ctrl_t             ctrl_val,
    output wr_sel_t           wr_sel,
    output logic [REG_W-1:0]  rd_data
);
    logic [N_REGS-1:0] hit;

    for (genvar g = 0; g < N_REGS; g++) begin : g_hit
        localparam logic [ADDR_W-1:0] MY_ADDR = BASE_ADDR + ADDR_W'(g);
        assign hit[g] = (addr == MY_ADDR);
    end

    always_comb begin
        wr_sel.div  = wr_en & hit[OFS_DIV];
        wr_sel.cnt  = wr_en & hit[OFS_CNT];
        wr_sel.rld  = wr_en & hit[OFS_RLD];
        wr_sel.ctrl = wr_en & hit[OFS_CTRL];
    end

    always_comb begin
        rd_data = '0;
        if (hit[OFS_DIV])  rd_data = div_val;
        if (hit[OFS_CNT])  rd_data = cnt_val;
        if (hit[OFS_RLD])  rd_data = rld_val;
        if (hit[OFS_CTRL]) rd_data = {5'b11111, ctrl_val};
    end
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              clear,
    input  ctrl_t             ctrl,
    output logic [BASE_W-1:0] base_q,
    output logic              step
);
    logic [BASE_W-1:0] base_nxt;

    assign base_nxt = base_q + BASE_W'(1);
    assign step = tick & ~clear & ctrl.run &
                  ((base_nxt & rate_mask(ctrl.rate)) == '0);

    always_ff @(posedge clk) begin
        if (rst)        base_q <= '0;
        else if (clear) base_q <= '0;
        else if (tick)  base_q <= base_nxt;
    end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
    import tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic             cnt_wr,
    input  logic             rld_wr,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] cnt_q,
    output logic [REG_W-1:0] rld_q,
    output logic             irq_q
);
    logic wrap;
    assign wrap = step & (cnt_q == '1) & ~cnt_wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            rld_q <= '0;
            irq_q <= 1'b0;
        end else begin
            irq_q <= wrap;
            if (rld_wr) rld_q <= wr_data;
            if (cnt_wr)    cnt_q <= wr_data;
            else if (wrap) cnt_q <= rld_q;
            else if (step) cnt_q <= cnt_q + REG_W'(1);
        end
    end
endmodule

// File: rtl/interval_timer.sv
module interval_timer
    import tmr_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter [ADDR_W-1:0] BASE_ADDR = 16'hFF04
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    output logic [REG_W-1:0]  rd_data,
    output logic              irq
);
    wr_sel_t           wsel;
    ctrl_t             ctrl_q;
    logic [BASE_W-1:0] base_q;
    logic              step;
    logic [REG_W-1:0]  cnt_q, rld_q;

    tmr_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
        .addr(addr), .wr_en(wr_en),
        .div_val(base_q[BASE_W-1 -: REG_W]), .cnt_val(cnt_q),
        .rld_val(rld_q), .ctrl_val(ctrl_q),
        .wr_sel(wsel), .rd_data(rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst)            ctrl_q <= '0;
        else if (wsel.ctrl) ctrl_q <= wr_data[2:0];
    end

    tmr_prescaler u_pre (
        .clk(clk), .rst(rst), .tick(tick), .clear(wsel.div),
        .ctrl(ctrl_q), .base_q(base_q), .step(step)
    );

    tmr_counter u_cnt (
        .clk(clk), .rst(rst), .step(step), .cnt_wr(wsel.cnt),
        .rld_wr(wsel.rld), .wr_data(wr_data),
        .cnt_q(cnt_q), .rld_q(rld_q), .irq_q(irq)
    );
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
    import tmr_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              tick,
    input logic              div_wr,
    input logic              cnt_wr,
    input logic              run,
    input logic [REG_W-1:0]  wr_data,
    input logic [BASE_W-1:0] base_q,
    input logic [REG_W-1:0]  cnt_q,
    input logic [REG_W-1:0]  rld_q,
    input logic              irq
);
    // R8
    irq_single_chk: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    // R5
    hold_when_off_chk: assert property (@(posedge clk) disable iff (rst)
        (!run && !cnt_wr) |=> $stable(cnt_q));

    // R4
    div_clear_chk: assert property (@(posedge clk) disable iff (rst)
        div_wr |=> (base_q == '0));

    // R3
    base_adv_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && !div_wr) |=> (base_q == $past(base_q) + BASE_W'(1)));

    // R9
    write_wins_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_wr |=> ((cnt_q == $past(wr_data)) && !irq));

    // R7
    reload_val_chk: assert property (@(posedge clk) disable iff (rst)
        (!cnt_wr && !rst) ##1 irq |-> (cnt_q == $past(rld_q)));
endmodule

bind interval_timer tmr_checker u_chk (
    .clk(clk), .rst(rst), .tick(tick), .div_wr(wsel.div),
    .cnt_wr(wsel.cnt), .run(ctrl_q.run), .wr_data(wr_data),
    .base_q(base_q), .cnt_q(cnt_q), .rld_q(rld_q), .irq(irq)
);

// File: tb/sim_interval_timer.sv
`timescale 1ns/1ps
module sim_interval_timer;
    localparam logic [15:0] BASE = 16'hFF04;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic [15:0] addr = 16'h0000;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       irq;

    int n_run  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    interval_timer u0 (
        .clk(clk), .rst(rst), .tick(tick), .addr(addr),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
    );

    // bench model built from the requirements
    logic [15:0] m_base;
    logic [7:0]  m_cnt, m_rld;
    logic [2:0]  m_ctrl;
    logic        m_irq;

    function automatic logic [15:0] period_mask(input logic [1:0] c);
        case (c)
            2'b00:   return 16'd1023;
            2'b01:   return 16'd15;
            2'b10:   return 16'd63;
            default: return 16'd255;
        endcase
    endfunction

    function automatic logic [7:0] model_read(input logic [15:0] a);
        if (a == BASE)        return m_base[15:8];
        if (a == BASE + 16'd1) return m_cnt;
        if (a == BASE + 16'd2) return m_rld;
        if (a == BASE + 16'd3) return {5'b11111, m_ctrl};
        return 8'h00;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_base <= '0; m_cnt <= '0; m_rld <= '0; m_ctrl <= '0; m_irq <= 1'b0;
        end else begin
            logic dw, cw, inc, ov;
            dw  = wr_en && addr == BASE;
            cw  = wr_en && addr == BASE + 16'd1;
            inc = tick && !dw && m_ctrl[2] &&
                  (((m_base + 16'd1) & period_mask(m_ctrl[1:0])) == 16'd0);
            ov  = inc && m_cnt == 8'hFF && !cw;
            m_irq <= ov;
            if (dw) m_base <= '0; else if (tick) m_base <= m_base + 16'd1;
            if (cw) m_cnt <= wr_data;
            else if (ov) m_cnt <= m_rld;
            else if (inc) m_cnt <= m_cnt + 8'd1;
            if (wr_en && addr == BASE + 16'd2) m_rld <= wr_data;
            if (wr_en && addr == BASE + 16'd3) m_ctrl <= wr_data[2:0];
        end
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // per-cycle comparison against the model, sampled mid-cycle
    bit model_on = 1'b0;
    always @(negedge clk) begin
        if (model_on && !rst) begin
            chk("R8 irq", {7'd0, irq}, {7'd0, m_irq});
            if (addr == BASE)             chk("R3 R4 divider", rd_data, model_read(addr));
            else if (addr == BASE + 16'd1) chk("R6 R7 R9 count", rd_data, model_read(addr));
            else if (addr == BASE + 16'd2) chk("R10 reload", rd_data, model_read(addr));
            else if (addr == BASE + 16'd3) chk("R10 control", rd_data, model_read(addr));
            else                          chk("R2 unmapped", rd_data, model_read(addr));
        end
    end

    // one cycle: drive at negedge, let edge pass, return at next negedge
    task automatic cyc(input logic t, input logic w, input logic [15:0] a, input logic [7:0] d);
        tick = t; wr_en = w; addr = a; wr_data = d;
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] ofs, input logic [7:0] d);
        cyc(1'b0, 1'b1, BASE + {14'd0, ofs}, d);
    endtask

    task automatic rd(input logic [1:0] ofs, input string req, input logic [7:0] exp);
        tick = 1'b0; wr_en = 1'b0; addr = BASE + {14'd0, ofs};
        #1;
        chk(req, rd_data, exp);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20211030));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        rd(2'd0, "R1", 8'h00); rd(2'd1, "R1", 8'h00);
        rd(2'd2, "R1", 8'h00); rd(2'd3, "R1", 8'hF8);
        chk("R1 irq", {7'd0, irq}, 8'h00);
        @(negedge clk);
        model_on = 1'b1;

        // R2 unmapped writes ignored
        cyc(1'b0, 1'b1, 16'hFF08, 8'h55);
        cyc(1'b0, 1'b1, 16'h0005, 8'h66);
        rd(2'd1, "R2", 8'h00);
        rd(2'd2, "R2", 8'h00);

        // R5 and R3: disabled counter holds, divider still runs
        wr(2'd3, 8'h01); wr(2'd1, 8'h20); wr(2'd0, 8'hAB);
        rd(2'd0, "R4", 8'h00);
        for (int i = 0; i < 2000; i++) cyc(1'b1, 1'b0, BASE + 16'd1, 8'h00);
        rd(2'd1, "R5", 8'h20);
        rd(2'd0, "R3", 8'd7);

        // R6 each rate: three periods give three increments
        for (int s = 0; s < 4; s++) begin
            int per;
            per = int'(period_mask(2'(s))) + 1;
            wr(2'd3, 8'h04 | 8'(s)); wr(2'd1, 8'h00); wr(2'd0, 8'h00);
            for (int i = 0; i < 3 * per - 1; i++) cyc(1'b1, 1'b0, BASE + 16'd1, 8'h00);
            rd(2'd1, "R6", 8'd2);
            cyc(1'b1, 1'b0, BASE + 16'd1, 8'h00);
            rd(2'd1, "R6", 8'd3);
        end

        // R7 R8 overflow reload
        wr(2'd2, 8'hF0); wr(2'd3, 8'h05); wr(2'd1, 8'hFF); wr(2'd0, 8'h00);
        for (int i = 0; i < 15; i++) cyc(1'b1, 1'b0, BASE + 16'd1, 8'h00);
        chk("R8 before", {7'd0, irq}, 8'h00);
        cyc(1'b1, 1'b0, BASE + 16'd1, 8'h00);
        chk("R8 pulse", {7'd0, irq}, 8'h01);
        rd(2'd1, "R7", 8'hF0);
        @(negedge clk);
        chk("R8 end", {7'd0, irq}, 8'h00);

        // R9 write collides with overflow
        wr(2'd1, 8'hFF); wr(2'd0, 8'h00);
        for (int i = 0; i < 15; i++) cyc(1'b1, 1'b0, BASE + 16'd1, 8'h00);
        cyc(1'b1, 1'b1, BASE + 16'd1, 8'h33);
        chk("R9 irq", {7'd0, irq}, 8'h00);
        rd(2'd1, "R9", 8'h33);
        rd(2'd3, "R10", 8'hFD);

        // random traffic, checked per cycle by the model
        for (int i = 0; i < 40000; i++) begin
            logic [15:0] a;
            logic        w;
            a = BASE + 16'($urandom_range(0, 4));
            w = ($urandom_range(0, 99) < 3);
            if (w && a == BASE + 16'd3 && $urandom_range(0, 1) == 1)
                cyc(($urandom_range(0, 9) < 8), 1'b1, a, 8'h05);
            else
                cyc(($urandom_range(0, 9) < 8), w, a, 8'($urandom));
        end

        model_on = 1'b0;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule